// File: doc/BRIEF.md
# Floppy Controller Host Register File

This block is the processor side of a floppy disk controller. A host bus uses an active-low select, a read/write line and a two-bit register address. Through these it reaches five byte-wide registers: command, status, track, sector and data. The block enforces the access rules of each register. It keeps the head-position (track) register in step with the stepper pulses issued by the command engine. It also tells the engine whether the current track and sector match the track and sector bytes taken from a recorded ID field.

The command engine is outside this block. It sees each accepted command as the command byte plus a one-cycle strobe. It returns a done pulse, step pulses, incoming data bytes and the upper status bits. The block turns these into a busy flag, a data request flag and an interrupt request flag. The host clears those flags as a side effect of reading the status and data registers.

There is no streaming interface here. Every pin is a plain control or status pin, and each cycle with the select low counts as one complete bus access.

Top module: `fdc_host_regs`

## Requirements
- R1: While `rst_n` is low and after it is released, the command register reads 0 on `cmd`, the sector register is 1, the track register is 0, the data register is 0, and `busy`, `drq`, `intrq` and `cmd_stb` are 0.
- R2: An access happens only in a cycle with `cs_n`=0. `rd_wr`=1 means a read and 0 means a write. Address 0 selects command (write) or status (read), 1 selects track, 2 selects sector and 3 selects data. `rd_data` is 0 whenever no read is in progress.
- R3: The command register cannot be read back. A read at address 0 returns the status byte, which is `{status_hi[5:0], drq, busy}`: bit 0 is busy and bit 1 is the data request.
- R4: A command write while not busy loads `cmd` at the next edge, raises `cmd_stb` for exactly one cycle and sets `busy`.
- R5: A command write while busy is dropped, leaving `cmd`, `busy` and `cmd_stb` unchanged. The exception is a force-interrupt command, whose upper nibble is 4'hD. That command is always accepted: it loads `cmd`, pulses `cmd_stb`, clears `busy` and sets `intrq`.
- R6: Host writes to the track and sector registers are ignored while `busy` is 1.
- R7: A `step_in` pulse adds one to the track register, and a `step_out` pulse subtracts one. The count stops at 255 on step-in and at 0 on step-out. Both pulses in the same cycle leave the track unchanged.
- R8: `track_match` is 1 exactly when the track register equals `id_track`, and `sector_match` is 1 exactly when the sector register equals `id_sector`.
- R9: The data register is written by the host at any time and loaded from `data_in` by `data_load`. The engine load wins if both happen in the same cycle. The register is always visible on `data_q`, where it serves as the seek target.
- R10: `drq` is set by `data_load` and cleared by a host read or write of the data register. A set in the same cycle as a clear wins.
- R11: `cmd_done` clears `busy` and sets `intrq`. A host status read clears `intrq`, but a set in the same cycle as a status read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| cs_n | input | 1 | Active-low register select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte (0 when not reading) |
| status_hi | input | 6 | Upper status bits from the command engine |
| cmd_done | input | 1 | Command finished pulse |
| step_in | input | 1 | Head stepped toward the spindle |
| step_out | input | 1 | Head stepped toward track 0 |
| data_load | input | 1 | Engine delivers a byte into the data register |
| data_in | input | 8 | Byte from the serial path |
| id_track | input | 8 | Track byte of the recorded ID field |
| id_sector | input | 8 | Sector byte of the recorded ID field |
| cmd | output | 8 | Command register |
| cmd_stb | output | 1 | One-cycle pulse on an accepted command |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| track | output | 8 | Track register |
| sector | output | 8 | Sector register |
| data_q | output | 8 | Data register / seek target |
| track_match | output | 1 | Track register equals ID track |
| sector_match | output | 1 | Sector register equals ID sector |

## Verification
Some rules can be checked on every cycle, and the assertions do that. A command dropped during busy leaves the command register still. Blocked track and sector writes leave those registers unchanged. The step counter moves by one or stops at its limits, the flags honour set priority, and the decoder never selects two registers at once.

Other behaviour can only be shown by the bench's scenarios. These include the exact contents of the status byte, and the requirement that the command register is never read back. They also include the force-interrupt path ending busy with an interrupt, the data register taking the engine byte over a host write in the same cycle, and the match flags following the ID bytes.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NREG   = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CMD_STAT = 2'd0,
    SEL_TRACK    = 2'd1,
    SEL_SECTOR   = 2'd2,
    SEL_DATA     = 2'd3
  } reg_sel_e;

  localparam logic [3:0] FORCE_INT_NIBBLE = 4'hD;
endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode #(
  parameter int unsigned AW = 2,
  localparam int unsigned N = 1 << AW
) (
  input  logic          cs_n,
  input  logic          rd_wr,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  wr_sel,
  output logic [N-1:0]  rd_sel
);
  logic acc_rd, acc_wr;

  assign acc_rd = !cs_n && rd_wr;
  assign acc_wr = !cs_n && !rd_wr;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign wr_sel[g] = acc_wr && (addr == AW'(g));
    assign rd_sel[g] = acc_rd && (addr == AW'(g));
  end
endmodule

// File: rtl/fdc_step_counter.sv
module fdc_step_counter #(
  parameter int unsigned W = 8,
  localparam logic [W-1:0] TOP = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (inc && !dec) begin
      if (value != TOP) value <= value + 1'b1;
    end else if (dec && !inc) begin
      if (value != '0) value <= value - 1'b1;
    end
  end

  assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !load && value == TOP) |=> value == TOP);
  assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !load && value != '0) |=> value == $past(value) - 1'b1);
  assert_sat_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !load && value == '0) |=> value == '0);
  assert_both_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && inc && !load) |=> $stable(value));
endmodule

// File: rtl/fdc_flag.sv
module fdc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // Set priority serves both R10 (drq) and R11 (intrq)
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  assert_flag_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_regs_pkg::*;
#(
  parameter int unsigned W = REG_W,
  localparam int unsigned SW = W - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_wr,
  input  logic [1:0]    addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  input  logic [SW-1:0] status_hi,
  input  logic          cmd_done,
  input  logic          step_in,
  input  logic          step_out,
  input  logic          data_load,
  input  logic [W-1:0]  data_in,
  input  logic [W-1:0]  id_track,
  input  logic [W-1:0]  id_sector,
  output logic [W-1:0]  cmd,
  output logic          cmd_stb,
  output logic          busy,
  output logic          drq,
  output logic          intrq,
  output logic [W-1:0]  track,
  output logic [W-1:0]  sector,
  output logic [W-1:0]  data_q,
  output logic          track_match,
  output logic          sector_match
);
  logic [NREG-1:0] wr_sel, rd_sel;
  logic is_fi, cmd_wr, cmd_take, cmd_norm, cmd_fi;
  logic trk_load, sec_load;
  logic [W-1:0] status_byte;

  fdc_bus_decode #(.AW(ADDR_W)) u_dec (
    .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  assign is_fi    = wr_data[W-1 -: 4] == FORCE_INT_NIBBLE;
  assign cmd_wr   = wr_sel[SEL_CMD_STAT];
  assign cmd_take = cmd_wr && (!busy || is_fi);
  assign cmd_fi   = cmd_take && is_fi;
  assign cmd_norm = cmd_take && !is_fi;
  assign trk_load = wr_sel[SEL_TRACK] && !busy;
  assign sec_load = wr_sel[SEL_SECTOR] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd     <= '0;
      cmd_stb <= 1'b0;
      busy    <= 1'b0;
      sector  <= W'(1);
      data_q  <= '0;
    end else begin
      cmd_stb <= cmd_take;
      if (cmd_take) cmd <= wr_data;
      if (cmd_norm)                busy <= 1'b1;
      else if (cmd_fi || cmd_done) busy <= 1'b0;
      if (sec_load) sector <= wr_data;
      if (data_load)                 data_q <= data_in;
      else if (wr_sel[SEL_DATA])     data_q <= wr_data;
    end
  end

  fdc_step_counter #(.W(W)) u_track (
    .clk(clk), .rst_n(rst_n), .load(trk_load), .load_val(wr_data),
    .inc(step_in), .dec(step_out), .value(track)
  );

  fdc_flag u_drq (
    .clk(clk), .rst_n(rst_n), .set(data_load),
    .clr(wr_sel[SEL_DATA] || rd_sel[SEL_DATA]), .q(drq)
  );

  fdc_flag u_intrq (
    .clk(clk), .rst_n(rst_n), .set(cmd_done || cmd_fi),
    .clr(rd_sel[SEL_CMD_STAT]), .q(intrq)
  );

  assign status_byte  = {status_hi, drq, busy};
  assign track_match  = track == id_track;
  assign sector_match = sector == id_sector;

  always_comb begin
    rd_data = '0;
    unique case (1'b1)
      rd_sel[SEL_CMD_STAT]: rd_data = status_byte;
      rd_sel[SEL_TRACK]:    rd_data = track;
      rd_sel[SEL_SECTOR]:   rd_data = sector;
      rd_sel[SEL_DATA]:     rd_data = data_q;
      default:              rd_data = '0;
    endcase
  end

  assert_one_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel | rd_sel));
  assert_idle_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !is_fi) |=> (busy && cmd_stb));
  assert_cmd_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy && !is_fi) |=> (cmd == $past(cmd) && !cmd_stb));
  assert_fi_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && is_fi) |=> (!busy && intrq));
  assert_trk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[SEL_TRACK] && busy && !step_in && !step_out) |=> $stable(track));
  assert_sec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[SEL_SECTOR] && busy) |=> $stable(sector));
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_load |=> data_q == $past(data_in));
endmodule

// File: tb/test_fdc_host_regs.sv
module test_fdc_host_regs;
  localparam time CYC = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_wr = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0, data_in = '0, id_track = '0, id_sector = '0;
  logic [5:0] status_hi = '0;
  logic cmd_done = 0, step_in = 0, step_out = 0, data_load = 0;
  logic [7:0] rd_data, cmd, track, sector, data_q;
  logic cmd_stb, busy, drq, intrq, track_match, sector_match;

  int total = 0;
  int bad = 0;

  always #(CYC/2) clk = ~clk;

  fdc_host_regs i_fdc_host_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .status_hi(status_hi),
    .cmd_done(cmd_done), .step_in(step_in), .step_out(step_out),
    .data_load(data_load), .data_in(data_in), .id_track(id_track),
    .id_sector(id_sector), .cmd(cmd), .cmd_stb(cmd_stb), .busy(busy),
    .drq(drq), .intrq(intrq), .track(track), .sector(sector),
    .data_q(data_q), .track_match(track_match), .sector_match(sector_match)
  );

  // Vector: [18] read, [17:16] address, [15:8] write byte, [7:0] expected read
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd1, 8'h22, 8'h00},
    {1'b0, 2'd2, 8'h05, 8'h00},
    {1'b0, 2'd3, 8'h7E, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h22},
    {1'b1, 2'd2, 8'h00, 8'h05},
    {1'b1, 2'd3, 8'h00, 8'h7E},
    {1'b1, 2'd0, 8'h00, 8'h00},
    {1'b0, 2'd1, 8'h91, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h91},
    {1'b1, 2'd2, 8'h00, 8'h05}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_wr = 1'b0; addr = a; wr_data = d;
    @(negedge clk);
    cs_n = 1'b1; rd_wr = 1'b1;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; rd_wr = 1'b1; addr = a;
    #1 v = rd_data;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic pulse_step(input logic up, input logic dn);
    @(negedge clk);
    step_in = up; step_out = dn;
    @(negedge clk);
    step_in = 1'b0; step_out = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  initial begin
    #(CYC * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset values held during reset
    chk("R1 sector in reset", sector, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd", cmd, 8'h00);
    chk("R1 sector", sector, 8'h01);
    chk("R1 track", track, 8'h00);
    chk("R1 data", data_q, 8'h00);
    chk("R1 flags", {4'b0, busy, drq, intrq, cmd_stb}, 8'h00);

    // R2 R3: table walk over all addresses while idle
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        host_rd(VEC[i][17:16], v);
        chk($sformatf("R2 vector %0d", i), v, VEC[i][7:0]);
      end else begin
        host_wr(VEC[i][17:16], VEC[i][15:8]);
      end
    end

    // R2: select high means no access; rd_data 0 when idle
    @(negedge clk);
    cs_n = 1'b1; rd_wr = 1'b0; addr = 2'd1; wr_data = 8'h77;
    #1 chk("R2 rd_data idle", rd_data, 8'h00);
    @(negedge clk);
    rd_wr = 1'b1;
    chk("R2 deselected write", track, 8'h91);

    // R4: command accepted while idle
    host_wr(2'd0, 8'h18);
    chk("R4 cmd loaded", cmd, 8'h18);
    chk("R4 busy", {7'b0, busy}, 8'h01);
    chk("R4 strobe", {7'b0, cmd_stb}, 8'h01);
    @(negedge clk);
    chk("R4 strobe one cycle", {7'b0, cmd_stb}, 8'h00);

    // R3: status layout, command never read back
    status_hi = 6'b101001;
    host_rd(2'd0, v);
    chk("R3 status byte", v, 8'hA5);

    // R6: track and sector writes ignored while busy
    host_wr(2'd1, 8'h55);
    chk("R6 track blocked", track, 8'h91);
    host_wr(2'd2, 8'h66);
    chk("R6 sector blocked", sector, 8'h05);

    // R5: normal command dropped, force interrupt accepted
    host_wr(2'd0, 8'h88);
    chk("R5 drop cmd", cmd, 8'h18);
    chk("R5 drop no strobe", {6'b0, busy, cmd_stb}, 8'h02);
    host_wr(2'd0, 8'hD0);
    chk("R5 fi cmd", cmd, 8'hD0);
    chk("R5 fi flags", {5'b0, busy, intrq, cmd_stb}, 8'h03);

    // R11: status read clears intrq
    status_hi = 6'b0;
    host_rd(2'd0, v);
    chk("R11 status before clear", v, 8'h00);
    chk("R11 intrq cleared", {7'b0, intrq}, 8'h00);
    host_wr(2'd0, 8'h18);
    pulse_done();
    chk("R11 done flags", {6'b0, busy, intrq}, 8'h01);
    @(negedge clk);
    cs_n = 1'b0; rd_wr = 1'b1; addr = 2'd0; cmd_done = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; cmd_done = 1'b0;
    chk("R11 set beats clear", {7'b0, intrq}, 8'h01);

    // R10 R9: engine byte, host read clears drq
    @(negedge clk);
    data_load = 1'b1; data_in = 8'h3C;
    @(negedge clk);
    data_load = 1'b0;
    chk("R10 drq set", {7'b0, drq}, 8'h01);
    chk("R9 engine byte", data_q, 8'h3C);
    host_rd(2'd3, v);
    chk("R9 read data", v, 8'h3C);
    chk("R10 drq cleared", {7'b0, drq}, 8'h00);
    @(negedge clk);
    cs_n = 1'b0; rd_wr = 1'b0; addr = 2'd3; wr_data = 8'h11;
    data_load = 1'b1; data_in = 8'h99;
    @(negedge clk);
    cs_n = 1'b1; rd_wr = 1'b1; data_load = 1'b0;
    chk("R9 engine wins", data_q, 8'h99);
    chk("R10 set wins", {7'b0, drq}, 8'h01);
    host_wr(2'd3, 8'h28);
    chk("R9 seek target", data_q, 8'h28);
    chk("R10 write clears", {7'b0, drq}, 8'h00);

    // R7: step counting and saturation
    host_wr(2'd1, 8'hFE);
    pulse_step(1'b1, 1'b0);
    chk("R7 step in", track, 8'hFF);
    pulse_step(1'b1, 1'b0);
    chk("R7 top saturate", track, 8'hFF);
    host_wr(2'd1, 8'h01);
    pulse_step(1'b0, 1'b1);
    chk("R7 step out", track, 8'h00);
    pulse_step(1'b0, 1'b1);
    chk("R7 zero saturate", track, 8'h00);
    host_wr(2'd1, 8'h40);
    pulse_step(1'b1, 1'b1);
    chk("R7 both no change", track, 8'h40);

    // R8: ID field compare
    id_track = 8'h40; id_sector = 8'h05;
    #1 chk("R8 both match", {6'b0, track_match, sector_match}, 8'h03);
    id_track = 8'h41; id_sector = 8'h06;
    #1 chk("R8 mismatch", {6'b0, track_match, sector_match}, 8'h00);
    id_track = 8'h40;
    #1 chk("R8 track only", {6'b0, track_match, sector_match}, 8'h02);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule